// File: doc/BRIEF.md
# Signed Vector Max/Min/Abs/Negate Unit

This unit applies one of four signed operations to 32-bit words: the larger of two operands, the smaller of two operands, the magnitude of the first operand, or the two's-complement negation of the first operand. A mode input selects how the word is read. It is either one signed 32-bit value, or two signed 16-bit lanes that are processed independently of each other.

Results that cannot be represented saturate to the largest positive value of their width. This occurs only for the magnitude or negation of the most negative value. Whenever that happens, an overflow output is raised. The result and the overflow flag are registered, so they appear one clock after the inputs are presented. A new operation may be issued on every clock.

Top module: `vmm_unit`

## Requirements
- R1: While `rst_n` is low, `result` is 0 and `ovf` is 0.
- R2: The result and flag for the inputs present at a rising edge appear after that edge and hold until the next one (latency of one clock). Back-to-back operations are accepted every cycle.
- R3: `opcode` encoding is 0 = MAX, 1 = MIN, 2 = ABS, 3 = NEG. With `vec_mode` = 0, MAX and MIN compare `op_a` and `op_b` as signed 32-bit values and return the larger or the smaller one.
- R4: With `vec_mode` = 1, MAX and MIN compare the high lanes (bits 31:16) and the low lanes (bits 15:0) separately as signed 16-bit values. Each lane may therefore come from a different operand.
- R5: Scalar ABS returns `op_a` unchanged when it is non-negative, and its negation when it is negative.
- R6: Vector ABS applies the R5 rule to each 16-bit lane of `op_a` on its own.
- R7: NEG returns the two's-complement negation of `op_a`, as a whole word in scalar mode and per 16-bit lane in vector mode. Zero negates to zero.
- R8: ABS or NEG of 0x80000000 in scalar mode gives 0x7FFFFFFF. In vector mode, a lane holding 0x8000 gives 0x7FFF. In both cases `ovf` is 1.
- R9: `ovf` is 0 for MAX and MIN, and for ABS and NEG when no lane saturates. In vector mode `ovf` is 1 when either lane saturates.
- R10: For ABS and NEG, `op_b` has no effect on `result` or `ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First operand, the only operand for ABS and NEG |
| op_b | input | 32 | Second operand for MAX and MIN |
| opcode | input | 2 | 0 MAX, 1 MIN, 2 ABS, 3 NEG |
| vec_mode | input | 1 | 0: one 32-bit value; 1: two 16-bit lanes |
| result | output | 32 | Registered result |
| ovf | output | 1 | Registered saturation flag |

## Verification
The bench uses operands whose lanes have opposite signs, so that the scalar and vector readings give different answers. An unsigned compare, or a comparison that leaks across the lane boundary, therefore returns the wrong operand in one lane. The most negative value is applied in each lane alone, in both lanes, and as a full word. A design without saturation would return 0x8000 or 0x80000000 with no flag, and a design with a crossed flag would raise `ovf` for the wrong lane. ABS is repeated with a changed `op_b`, and operations are issued back to back, to catch a leak from the second operand and a wrong pipeline depth.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 2;

  typedef enum logic [1:0] {
    OP_MAX = 2'd0,
    OP_MIN = 2'd1,
    OP_ABS = 2'd2,
    OP_NEG = 2'd3
  } vmm_op_e;
endpackage

// File: rtl/vmm_lane.sv
module vmm_lane
  import vmm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  vmm_op_e      op,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  function automatic logic [W-1:0] pick_max(input logic [W-1:0] x, input logic [W-1:0] y);
    return ($signed(x) >= $signed(y)) ? x : y;
  endfunction

  function automatic logic [W-1:0] pick_min(input logic [W-1:0] x, input logic [W-1:0] y);
    return ($signed(x) <= $signed(y)) ? x : y;
  endfunction

  // {saturated, value}
  function automatic logic [W:0] neg_sat(input logic [W-1:0] x);
    logic [W-1:0] n;
    n = ~x + 1'b1;
    if (x == MOST_NEG) return {1'b1, MOST_POS};
    return {1'b0, n};
  endfunction

  function automatic logic [W:0] abs_sat(input logic [W-1:0] x);
    if (x[W-1]) return neg_sat(x);
    return {1'b0, x};
  endfunction

  logic [W:0] neg_out;
  logic [W:0] abs_out;

  assign neg_out = neg_sat(a);
  assign abs_out = abs_sat(a);

  always_comb begin
    res = '0;
    sat = 1'b0;
    unique case (op)
      OP_MAX: res = pick_max(a, b);
      OP_MIN: res = pick_min(a, b);
      OP_ABS: {sat, res} = abs_out;
      OP_NEG: {sat, res} = neg_out;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/vmm_unit.sv
module vmm_unit
  import vmm_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  parameter int LANES_P  = LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W_P-1:0] op_a,
  input  logic [WORD_W_P-1:0] op_b,
  input  logic [1:0]        opcode,
  input  logic              vec_mode,
  output logic [WORD_W_P-1:0] result,
  output logic              ovf
);
  localparam int LANE_W = WORD_W_P / LANES_P;

  vmm_op_e             op_dec;
  logic [WORD_W_P-1:0] scal_res;
  logic                scal_sat;
  logic [WORD_W_P-1:0] vec_res;
  logic [LANES_P-1:0]  lane_sat;
  logic [WORD_W_P-1:0] next_res;
  logic                next_ovf;

  assign op_dec = vmm_op_e'(opcode);

  vmm_lane #(.W(WORD_W_P)) u_scalar (
    .a   (op_a),
    .b   (op_b),
    .op  (op_dec),
    .res (scal_res),
    .sat (scal_sat)
  );

  for (genvar g = 0; g < LANES_P; g++) begin : g_lane
    vmm_lane #(.W(LANE_W)) u_lane (
      .a   (op_a[g*LANE_W +: LANE_W]),
      .b   (op_b[g*LANE_W +: LANE_W]),
      .op  (op_dec),
      .res (vec_res[g*LANE_W +: LANE_W]),
      .sat (lane_sat[g])
    );
  end

  assign next_res = vec_mode ? vec_res : scal_res;
  assign next_ovf = vec_mode ? (|lane_sat) : scal_sat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      ovf    <= 1'b0;
    end else begin
      result <= next_res;
      ovf    <= next_ovf;
    end
  end
endmodule

// File: rtl/vmm_unit_checker.sv
module vmm_unit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [1:0]  opcode,
  input logic        vec_mode,
  input logic [31:0] result,
  input logic        ovf,
  input logic [1:0]  lane_sat
);
  // R9: MAX/MIN never flag
  a_r9_minmax_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode[1] == 1'b0) |=> !ovf);

  // R8: flag always comes with a saturated value
  a_r8_flag_means_sat: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (result == 32'h7FFFFFFF || result[31:16] == 16'h7FFF || result[15:0] == 16'h7FFF));

  // R8: low lane at most negative saturates
  a_r8_low_lane_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mode && opcode[1] && op_a[15:0] == 16'h8000) |=> (ovf && result[15:0] == 16'h7FFF));

  // R3: scalar MAX/MIN returns one of the operands
  a_r3_pick_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_mode && !opcode[1]) |=> (result == $past(op_a) || result == $past(op_b)));

  // R4: each vector lane comes from one of the operands' lanes
  a_r4_lane_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mode && !opcode[1]) |=>
      ((result[31:16] == $past(op_a[31:16]) || result[31:16] == $past(op_b[31:16])) &&
       (result[15:0]  == $past(op_a[15:0])  || result[15:0]  == $past(op_b[15:0]))));

  // R5: scalar ABS is never negative
  a_r5_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_mode && opcode == 2'd2) |=> !result[31]);

  // R6: vector ABS lanes are never negative
  a_r6_lane_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mode && opcode == 2'd2) |=> (!result[31] && !result[15]));

  // R9: in vector mode the flag follows the lane saturations
  a_r9_lane_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mode && lane_sat == 2'b00) |=> !ovf);
endmodule

bind vmm_unit vmm_unit_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_a     (op_a),
  .op_b     (op_b),
  .opcode   (opcode),
  .vec_mode (vec_mode),
  .result   (result),
  .ovf      (ovf),
  .lane_sat (lane_sat)
);

// File: tb/vmm_unit_test.sv
module vmm_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = 32'h1234_5678;
  logic [31:0] op_b = 32'h9ABC_DEF0;
  logic [1:0]  opcode = 2'd0;
  logic        vec_mode = 1'b0;
  logic [31:0] result;
  logic        ovf;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  vmm_unit uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .vec_mode(vec_mode), .result(result), .ovf(ovf)
  );

  // Reference model: lane values as wide integers, clamped.
  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [1:0] op, input bit vec,
                                output logic [31:0] r, output bit o);
    int n = vec ? 2 : 1;
    int w = 32 / n;
    longint mask = (longint'(1) << w) - 1;
    longint hi = (longint'(1) << (w - 1)) - 1;
    longint lo = -(longint'(1) << (w - 1));
    longint acc = 0;
    o = 1'b0;
    for (int k = 0; k < n; k++) begin
      longint xa = (longint'(a) >> (k * w)) & mask;
      longint xb = (longint'(b) >> (k * w)) & mask;
      longint v;
      if (xa > hi) xa = xa - (mask + 1);
      if (xb > hi) xb = xb - (mask + 1);
      case (op)
        2'd0: v = (xa > xb) ? xa : xb;
        2'd1: v = (xa < xb) ? xa : xb;
        2'd2: v = (xa < 0) ? -xa : xa;
        default: v = -xa;
      endcase
      if (v > hi) begin v = hi; o = 1'b1; end
      if (v < lo) v = lo;
      acc = acc | ((v & mask) << (k * w));
    end
    r = 32'(acc);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op, input bit vec);
    @(negedge clk);
    op_a = a; op_b = b; opcode = op; vec_mode = vec;
  endtask

  task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] op, input bit vec,
                     input logic [31:0] exp_r, input bit exp_o);
    drive(a, b, op, vec);
    @(negedge clk);
    check(req, result, exp_r);
    check({req, " ovf"}, {31'd0, ovf}, {31'd0, exp_o});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 result in reset", result, 32'h0);
    check("R1 ovf in reset", {31'd0, ovf}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_scalar_minmax;
    run("R3 scalar max", 32'h456789AB, 32'h6789ABCD, 2'd0, 1'b0, 32'h6789ABCD, 1'b0);
    run("R3 scalar min", 32'h456789AB, 32'h6789ABCD, 2'd1, 1'b0, 32'h456789AB, 1'b0);
    run("R3 scalar max signed", 32'h7FFF8000, 32'h80007FFF, 2'd0, 1'b0, 32'h7FFF8000, 1'b0);
    run("R3 scalar min signed", 32'h7FFF8000, 32'h80007FFF, 2'd1, 1'b0, 32'h80007FFF, 1'b0);
  endtask

  task automatic t_vector_minmax;
    run("R4 vector max mixed", 32'h7FFF8000, 32'h80007FFF, 2'd0, 1'b1, 32'h7FFF7FFF, 1'b0);
    run("R4 vector min mixed", 32'h7FFF8000, 32'h80007FFF, 2'd1, 1'b1, 32'h80008000, 1'b0);
    run("R4 vector max doc", 32'h456789AB, 32'h6789ABCD, 2'd0, 1'b1, 32'h6789ABCD, 1'b0);
  endtask

  task automatic t_abs;
    run("R5 scalar abs pos", 32'h456789AB, 32'h0, 2'd2, 1'b0, 32'h456789AB, 1'b0);
    run("R5 scalar abs neg", 32'hFFFFFFFE, 32'h0, 2'd2, 1'b0, 32'h00000002, 1'b0);
    run("R6 vector abs", 32'h456789AB, 32'h0, 2'd2, 1'b1, 32'h45677655, 1'b0);
  endtask

  task automatic t_neg;
    run("R7 vector neg", 32'h456789AB, 32'h0, 2'd3, 1'b1, 32'hBA997655, 1'b0);
    run("R7 scalar neg", 32'h00000001, 32'h0, 2'd3, 1'b0, 32'hFFFFFFFF, 1'b0);
    run("R7 neg zero", 32'h00000000, 32'h0, 2'd3, 1'b0, 32'h00000000, 1'b0);
  endtask

  task automatic t_saturate;
    run("R8 scalar abs min", 32'h80000000, 32'h0, 2'd2, 1'b0, 32'h7FFFFFFF, 1'b1);
    run("R8 scalar neg min", 32'h80000000, 32'h0, 2'd3, 1'b0, 32'h7FFFFFFF, 1'b1);
    run("R8 R9 high lane only", 32'h80000005, 32'h0, 2'd3, 1'b1, 32'h7FFFFFFB, 1'b1);
    run("R8 R9 low lane only", 32'h00038000, 32'h0, 2'd2, 1'b1, 32'h00037FFF, 1'b1);
    run("R8 both lanes", 32'h80008000, 32'h0, 2'd3, 1'b1, 32'h7FFF7FFF, 1'b1);
    run("R9 min no flag", 32'h80000000, 32'h80000000, 2'd1, 1'b0, 32'h80000000, 1'b0);
  endtask

  task automatic t_ignore_b;
    run("R10 abs b=0", 32'hC0001234, 32'h00000000, 2'd2, 1'b0, 32'h3FFFEDCC, 1'b0);
    run("R10 abs b=max", 32'hC0001234, 32'hFFFFFFFF, 2'd2, 1'b0, 32'h3FFFEDCC, 1'b0);
    run("R10 neg b=80008000", 32'h00010002, 32'h80008000, 2'd3, 1'b1, 32'hFFFFFFFE, 1'b0);
  endtask

  task automatic t_pipeline;
    drive(32'h00000005, 32'h00000009, 2'd0, 1'b0);
    drive(32'h00000005, 32'h00000009, 2'd1, 1'b0);
    check("R2 first of pair", result, 32'h00000009);
    drive(32'h80000000, 32'h0, 2'd3, 1'b0);
    check("R2 second of pair", result, 32'h00000005);
    @(negedge clk);
    check("R2 third of run", result, 32'h7FFFFFFF);
    check("R2 held", result, 32'h7FFFFFFF);
  endtask

  task automatic t_sweep;
    logic [31:0] vals [6] = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFF0001,
                              32'h00017FFF, 32'h8000FFFF};
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int op = 0; op < 4; op++)
          for (int v = 0; v < 2; v++) begin
            logic [31:0] er;
            bit eo;
            model(vals[i], vals[j], 2'(op), v[0], er, eo);
            run("R3 R4 R6 R7 R8 sweep", vals[i], vals[j], 2'(op), v[0], er, eo);
          end
  endtask

  initial begin
    t_reset();
    t_scalar_minmax();
    t_vector_minmax();
    t_abs();
    t_neg();
    t_saturate();
    t_ignore_b();
    t_pipeline();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule